// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block tracks memory operations that are in flight in an out-of-order core. It keeps them in program order and decides, each cycle, which of them may go to the memory pipeline. The dispatch stage allocates one typed entry per cycle. An entry is a load, a store, a load fence, a store fence or a full fence. Allocation succeeds only when the entry's queue has room. The block returns the slot index it picked. The execution side reports a finished load or store by slot index. Entries are released in the order they finish, not in program order.

The ordering is relaxed. Loads may overtake other loads. Stores overtake nothing that reaches the memory pipeline. A load may overtake older stores only while the global no-alias input is high. Fences are soft: they never execute in a pipeline. A fence stays until it is the oldest entry of the queue or queues it belongs to, and it then drops out by itself. The block compares no addresses, so every load is assumed to overlap every store.

Top module: `mem_order_queue`

## Requirements
- R1: After a synchronous reset, no slot is occupied and `may_exec` is all zero. `lq_free` equals the load capacity, `sq_free` equals the store capacity, and both full flags are low.
- R2: A store is eligible only when no older load, store, store fence or full fence is present. It does not wait for an older load fence.
- R3: A load with an older store present is not eligible while `no_alias` is 0. With `no_alias` at 1, older stores do not hold it back.
- R4: A load is not held back by older loads. Several loads can be eligible in the same cycle.
- R5: A load is not eligible while an older load fence or full fence is present, whatever `no_alias` is. Neither fence holds back an older entry.
- R6: A fence never shows in `may_exec`. A load fence is released at the first clock edge at which no older load, load fence or full fence is present. A store fence needs no older store, store fence or full fence. A full fence needs no older entry at all.
- R7: `done_valid` with `done_slot` naming a slot whose `may_exec` bit is high releases that slot at the next edge. A completion for any other slot is ignored, and the entry stays.
- R8: Kind codes are: 0 load, 1 store, 2 load fence, 3 store fence, 4 full fence. Codes 5 to 7 are refused. `alloc_slot` shows the lowest-numbered free slot, or 0 when every slot is taken. `alloc_ok` is high when the request is taken, and the entry is present from the next cycle.
- R9: Loads and load fences take one load-queue entry. Stores and store fences take one store-queue entry. A full fence takes one of each but only one slot. A queue size of 0 gives that queue the whole slot count. `lq_free`/`sq_free` is the smaller of the queue's remaining room and the number of free slots.
- R10: A request whose queue(s) have a free count of 0 is refused (`alloc_ok` low, nothing stored), and the matching full flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 3 | Kind code of the requested entry |
| no_alias | input | 1 | Lets loads pass older stores |
| done_valid | input | 1 | Completion report |
| done_slot | input | $clog2(SLOTS) | Slot that finished |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_slot | output | $clog2(SLOTS) | Slot given to the request |
| may_exec | output | SLOTS | Per-slot eligibility to execute |
| lq_free | output | $clog2(SLOTS+1) | Free load-queue entries |
| sq_free | output | $clog2(SLOTS+1) | Free store-queue entries |
| lq_full | output | 1 | Load queue cannot accept |
| sq_full | output | 1 | Store queue cannot accept |

## Verification
A corrupted age relation or a stale slot shows within one cycle. It appears as a wrong `may_exec` bit on some slot, or as a wrong free count. The bench keeps its own entry list, with sequence numbers for age, and checks every output on every cycle. A fence stuck in the table is easy to miss, because it never reaches `may_exec`. It still shows up as held-back younger loads or stores, and as a free count one below the model's, from the cycle it should have left.

// File: rtl/mo_pkg.sv
package mo_pkg;

    typedef enum logic [2:0] {
        MK_LOAD  = 3'd0,
        MK_STORE = 3'd1,
        MK_LFEN  = 3'd2,
        MK_SFEN  = 3'd3,
        MK_FFEN  = 3'd4
    } mem_kind_e;

    function automatic logic kind_legal(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic takes_lq(input logic [2:0] k);
        return (k == MK_LOAD) || (k == MK_LFEN) || (k == MK_FFEN);
    endfunction

    function automatic logic takes_sq(input logic [2:0] k);
        return (k == MK_STORE) || (k == MK_SFEN) || (k == MK_FFEN);
    endfunction

endpackage

// File: rtl/mo_age_matrix.sv
module mo_age_matrix #(
    parameter int SLOTS = 8,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         alloc_en,
    input  logic [IW-1:0]                alloc_idx,
    input  logic [SLOTS-1:0]             valid,
    input  logic [SLOTS-1:0]             release_mask,
    output logic [SLOTS-1:0][SLOTS-1:0]  older
);
    // older[i][j] set: slot j was allocated before slot i and is still live
    logic [SLOTS-1:0][SLOTS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                for (int j = 0; j < SLOTS; j++) begin
                    if (alloc_en && alloc_idx == IW'(i))
                        older_q[i][j] <= valid[j] && !release_mask[j];
                    else if (release_mask[j])
                        older_q[i][j] <= 1'b0;
                end
            end
        end
    end

    assign older = older_q;
endmodule

// File: rtl/mo_rules.sv
module mo_rules
    import mo_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic [SLOTS-1:0]             valid,
    input  logic [SLOTS-1:0][2:0]        kind,
    input  logic [SLOTS-1:0][SLOTS-1:0]  older,
    input  logic                         no_alias,
    output logic [SLOTS-1:0]             may_exec,
    output logic [SLOTS-1:0]             fence_drop
);
    logic [SLOTS-1:0] is_ld, is_st, is_lf, is_sf, is_ff;

    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            is_ld[j] = valid[j] && kind[j] == MK_LOAD;
            is_st[j] = valid[j] && kind[j] == MK_STORE;
            is_lf[j] = valid[j] && kind[j] == MK_LFEN;
            is_sf[j] = valid[j] && kind[j] == MK_SFEN;
            is_ff[j] = valid[j] && kind[j] == MK_FFEN;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [SLOTS-1:0] ahead;
        logic             ld_ok, st_ok;
        logic             lf_clear, sf_clear, ff_clear;

        always_comb begin
            ahead    = older[i] & valid;
            ld_ok    = ~|(ahead & (is_lf | is_ff)) &&
                       (no_alias || ~|(ahead & is_st));
            st_ok    = ~|(ahead & (is_ld | is_st | is_sf | is_ff));
            lf_clear = ~|(ahead & (is_ld | is_lf | is_ff));
            sf_clear = ~|(ahead & (is_st | is_sf | is_ff));
            ff_clear = ~|ahead;
            may_exec[i]   = (is_ld[i] && ld_ok) || (is_st[i] && st_ok);
            fence_drop[i] = (is_lf[i] && lf_clear) ||
                            (is_sf[i] && sf_clear) ||
                            (is_ff[i] && ff_clear);
        end
    end
endmodule

// File: rtl/mo_occupancy.sv
module mo_occupancy #(
    parameter int SLOTS   = 8,
    parameter int LQ_SIZE = 6,
    parameter int SQ_SIZE = 4,
    localparam int IW     = $clog2(SLOTS),
    localparam int CW     = $clog2(SLOTS + 1),
    localparam int LQ_CAP = (LQ_SIZE == 0) ? SLOTS : LQ_SIZE,
    localparam int SQ_CAP = (SQ_SIZE == 0) ? SLOTS : SQ_SIZE
) (
    input  logic [SLOTS-1:0] valid,
    input  logic [SLOTS-1:0] lq_mask,
    input  logic [SLOTS-1:0] sq_mask,
    output logic [IW-1:0]    first_free,
    output logic [CW-1:0]    lq_free,
    output logic [CW-1:0]    sq_free
);
    logic [CW-1:0] used, lq_used, sq_used;
    logic [CW-1:0] slot_room, lq_room, sq_room;

    always_comb begin
        used    = '0;
        lq_used = '0;
        sq_used = '0;
        for (int i = 0; i < SLOTS; i++) begin
            used    = used    + CW'(valid[i]);
            lq_used = lq_used + CW'(valid[i] && lq_mask[i]);
            sq_used = sq_used + CW'(valid[i] && sq_mask[i]);
        end
        slot_room = CW'(SLOTS)  - used;
        lq_room   = CW'(LQ_CAP) - lq_used;
        sq_room   = CW'(SQ_CAP) - sq_used;
        lq_free   = (lq_room < slot_room) ? lq_room : slot_room;
        sq_free   = (sq_room < slot_room) ? sq_room : slot_room;
    end

    always_comb begin
        first_free = '0;
        for (int i = SLOTS - 1; i >= 0; i--)
            if (!valid[i]) first_free = IW'(i);
    end
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
    import mo_pkg::*;
#(
    parameter int SLOTS   = 8,
    parameter int LQ_SIZE = 6,
    parameter int SQ_SIZE = 4,
    localparam int IW     = $clog2(SLOTS),
    localparam int CW     = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic [2:0]       alloc_kind,
    input  logic             no_alias,
    input  logic             done_valid,
    input  logic [IW-1:0]    done_slot,
    output logic             alloc_ok,
    output logic [IW-1:0]    alloc_slot,
    output logic [SLOTS-1:0] may_exec,
    output logic [CW-1:0]    lq_free,
    output logic [CW-1:0]    sq_free,
    output logic             lq_full,
    output logic             sq_full
);
    logic [SLOTS-1:0]            valid_q;
    logic [SLOTS-1:0][2:0]       kind_q;
    logic [SLOTS-1:0][SLOTS-1:0] older;
    logic [SLOTS-1:0]            fence_drop;
    logic [SLOTS-1:0]            done_mask;
    logic [SLOTS-1:0]            release_mask;
    logic [SLOTS-1:0]            lq_mask, sq_mask;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            lq_mask[i] = takes_lq(kind_q[i]);
            sq_mask[i] = takes_sq(kind_q[i]);
        end
    end

    mo_age_matrix #(.SLOTS(SLOTS)) u_age (
        .clk          (clk),
        .rst          (rst),
        .alloc_en     (alloc_ok),
        .alloc_idx    (alloc_slot),
        .valid        (valid_q),
        .release_mask (release_mask),
        .older        (older)
    );

    mo_rules #(.SLOTS(SLOTS)) u_rules (
        .valid      (valid_q),
        .kind       (kind_q),
        .older      (older),
        .no_alias   (no_alias),
        .may_exec   (may_exec),
        .fence_drop (fence_drop)
    );

    mo_occupancy #(.SLOTS(SLOTS), .LQ_SIZE(LQ_SIZE), .SQ_SIZE(SQ_SIZE)) u_occ (
        .valid      (valid_q),
        .lq_mask    (lq_mask),
        .sq_mask    (sq_mask),
        .first_free (alloc_slot),
        .lq_free    (lq_free),
        .sq_free    (sq_free)
    );

    assign lq_full = (lq_free == '0);
    assign sq_full = (sq_free == '0);

    assign alloc_ok = alloc_valid && kind_legal(alloc_kind) &&
                      (!takes_lq(alloc_kind) || !lq_full) &&
                      (!takes_sq(alloc_kind) || !sq_full);

    always_comb begin
        done_mask = '0;
        for (int i = 0; i < SLOTS; i++)
            if (done_valid && done_slot == IW'(i) && may_exec[i])
                done_mask[i] = 1'b1;
    end

    assign release_mask = done_mask | fence_drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            kind_q  <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (release_mask[i]) valid_q[i] <= 1'b0;
                if (alloc_ok && alloc_slot == IW'(i)) begin
                    valid_q[i] <= 1'b1;
                    kind_q[i]  <= alloc_kind;
                end
            end
        end
    end
endmodule

// File: rtl/mo_checker.sv
module mo_checker #(
    parameter int SLOTS   = 8,
    parameter int LQ_SIZE = 6,
    localparam int IW     = $clog2(SLOTS),
    localparam int CW     = $clog2(SLOTS + 1),
    localparam int LQ_CAP = (LQ_SIZE == 0) ? SLOTS : LQ_SIZE
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   alloc_valid,
    input logic [2:0]             alloc_kind,
    input logic                   alloc_ok,
    input logic [IW-1:0]          alloc_slot,
    input logic                   done_valid,
    input logic [IW-1:0]          done_slot,
    input logic [SLOTS-1:0]       may_exec,
    input logic [CW-1:0]          lq_free,
    input logic [SLOTS-1:0]       valid_q,
    input logic [SLOTS-1:0][2:0]  kind_q
);
    logic [SLOTS-1:0] st_slots, fen_slots;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            st_slots[i]  = valid_q[i] && kind_q[i] == 3'd1;
            fen_slots[i] = valid_q[i] && kind_q[i] >= 3'd2;
        end
    end

    AST_ONE_STORE_READY: assert property (@(posedge clk) disable iff (rst)
        $countones(may_exec & st_slots) <= 1); // R2

    AST_FENCE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (may_exec & fen_slots) == '0); // R6

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        done_valid && may_exec[done_slot] |=> !valid_q[$past(done_slot)]); // R7

    AST_ALLOC_TARGET_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc_ok |-> !valid_q[alloc_slot]); // R8

    AST_LQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(lq_free) <= LQ_CAP); // R9

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && alloc_kind == 3'd0 && lq_free == '0 |-> !alloc_ok); // R10
endmodule

bind mem_order_queue mo_checker #(.SLOTS(SLOTS), .LQ_SIZE(LQ_SIZE)) u_mo_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .alloc_kind  (alloc_kind),
    .alloc_ok    (alloc_ok),
    .alloc_slot  (alloc_slot),
    .done_valid  (done_valid),
    .done_slot   (done_slot),
    .may_exec    (may_exec),
    .lq_free     (lq_free),
    .valid_q     (valid_q),
    .kind_q      (kind_q)
);

// File: tb/tb_mem_order_queue.sv
module tb_mem_order_queue;
    localparam int N   = 8;
    localparam int LQC = 4;
    localparam int SQC = 8;   // store queue size 0 -> whole table

    logic       clk = 1'b0;
    logic       rst;
    logic       alloc_valid;
    logic [2:0] alloc_kind;
    logic       no_alias;
    logic       done_valid;
    logic [2:0] done_slot;
    logic       alloc_ok;
    logic [2:0] alloc_slot;
    logic [7:0] may_exec;
    logic [3:0] lq_free, sq_free;
    logic       lq_full, sq_full;

    always #5 clk = ~clk;

    mem_order_queue #(.SLOTS(N), .LQ_SIZE(LQC), .SQ_SIZE(0)) dut (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
        .no_alias(no_alias), .done_valid(done_valid), .done_slot(done_slot),
        .alloc_ok(alloc_ok), .alloc_slot(alloc_slot), .may_exec(may_exec),
        .lq_free(lq_free), .sq_free(sq_free), .lq_full(lq_full), .sq_full(sq_full)
    );

    // behavioural model: slot list with sequence numbers as age
    bit mv[N];
    int mk[N];
    int mage[N];
    int seq;
    bit nal;
    int total = 0;
    int bad   = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_older(int j, int i);
        return mv[j] && mage[j] < mage[i];
    endfunction

    function automatic bit exp_may(int i);
        if (!mv[i]) return 0;
        for (int j = 0; j < N; j++) begin
            if (!is_older(j, i)) continue;
            if (mk[i] == 0) begin
                if (mk[j] == 2 || mk[j] == 4) return 0;
                if (mk[j] == 1 && !nal) return 0;
            end else if (mk[i] == 1) begin
                if (mk[j] != 2) return 0;
            end
        end
        return (mk[i] == 0 || mk[i] == 1);
    endfunction

    function automatic bit exp_drop(int i);
        if (!mv[i] || mk[i] < 2) return 0;
        for (int j = 0; j < N; j++) begin
            if (!is_older(j, i)) continue;
            if (mk[i] == 4) return 0;
            if (mk[i] == 2 && (mk[j] == 0 || mk[j] == 2 || mk[j] == 4)) return 0;
            if (mk[i] == 3 && (mk[j] == 1 || mk[j] == 3 || mk[j] == 4)) return 0;
        end
        return 1;
    endfunction

    function automatic string may_tag(int i);
        bit st_ahead = 0, fen_ahead = 0;
        if (mv[i] && mk[i] >= 2) return "R6 fence eligibility";
        if (mv[i] && mk[i] == 1) return "R2 store eligibility";
        for (int j = 0; j < N; j++) begin
            if (is_older(j, i) && mk[j] == 1) st_ahead = 1;
            if (is_older(j, i) && (mk[j] == 2 || mk[j] == 4)) fen_ahead = 1;
        end
        if (fen_ahead) return "R5 load behind fence";
        if (st_ahead)  return "R3 load behind store";
        return "R4 load eligibility";
    endfunction

    task automatic step(bit av, int ak, bit dv, int ds, bit na);
        int used = 0, lqu = 0, squ = 0, lqf, sqf, eslot = 0;
        bit found = 0, nlq, nsq, eok;
        bit emay[N];
        bit freed[N];
        @(negedge clk);
        alloc_valid = av; alloc_kind = ak[2:0];
        done_valid = dv;  done_slot = ds[2:0];
        no_alias = na;    nal = na;
        #2;
        for (int i = 0; i < N; i++) begin
            emay[i] = exp_may(i);
            if (mv[i]) begin
                used++;
                if (mk[i] == 0 || mk[i] == 2 || mk[i] == 4) lqu++;
                if (mk[i] == 1 || mk[i] == 3 || mk[i] == 4) squ++;
            end else if (!found) begin
                found = 1; eslot = i;
            end
            chk(may_tag(i), int'(may_exec[i]), int'(emay[i]));
        end
        lqf = (LQC - lqu < N - used) ? LQC - lqu : N - used;
        sqf = (SQC - squ < N - used) ? SQC - squ : N - used;
        nlq = (ak == 0 || ak == 2 || ak == 4);
        nsq = (ak == 1 || ak == 3 || ak == 4);
        eok = av && ak <= 4 && (!nlq || lqf > 0) && (!nsq || sqf > 0);
        chk("R9 lq_free", int'(lq_free), lqf);
        chk("R9 sq_free", int'(sq_free), sqf);
        chk("R10 lq_full", int'(lq_full), int'(lqf == 0));
        chk("R10 sq_full", int'(sq_full), int'(sqf == 0));
        chk("R8 alloc_slot", int'(alloc_slot), eslot);
        chk(ak <= 4 ? "R10 alloc_ok" : "R8 illegal kind", int'(alloc_ok), int'(eok));
        for (int i = 0; i < N; i++)
            freed[i] = exp_drop(i) || (dv && ds == i && emay[i]);
        for (int i = 0; i < N; i++)
            if (freed[i]) mv[i] = 0;
        if (eok) begin
            mv[eslot] = 1; mk[eslot] = ak; mage[eslot] = seq; seq++;
        end
    endtask

    task automatic idle(bit na);
        step(0, 0, 0, 0, na);
    endtask

    task automatic drain();
        for (int n = 0; n < 40; n++) begin
            int pick = -1;
            for (int i = N - 1; i >= 0; i--) if (exp_may(i)) pick = i;
            if (pick >= 0) step(0, 0, 1, pick, 0);
            else idle(0);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired R1 act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seq = 0;
        for (int i = 0; i < N; i++) begin mv[i] = 0; mk[i] = 0; mage[i] = 0; end
        rst = 1; alloc_valid = 0; alloc_kind = 0; done_valid = 0; done_slot = 0; no_alias = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        idle(0);
        chk("R1 may_exec after reset", int'(may_exec), 0);
        chk("R1 lq_free after reset", int'(lq_free), LQC);
        chk("R1 sq_free after reset", int'(sq_free), SQC);

        // loads, a store, a younger load
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        idle(0);
        chk("R4 two loads eligible together", int'(may_exec), 8'b0000_0011);
        chk("R3 load held behind store", int'(may_exec[3]), 0);
        idle(1);
        chk("R3 no_alias frees younger load", int'(may_exec), 8'b0000_1011);
        step(0, 0, 1, 2, 0);           // store not eligible: ignored
        idle(0);
        chk("R7 completion of blocked store ignored", int'(may_exec), 8'b0000_0011);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 1, 0);
        idle(0);
        chk("R2 store eligible once loads done", int'(may_exec), 8'b0000_0100);
        drain();

        // load fence between loads
        step(1, 0, 0, 0, 0);
        step(1, 2, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        idle(1);
        chk("R5 load held behind load fence", int'(may_exec), 8'b0000_0001);
        step(0, 0, 1, 0, 0);
        idle(0);
        chk("R6 fence still present one cycle", int'(may_exec), 0);
        idle(0);
        chk("R6 fence gone, younger load free", int'(may_exec), 8'b0000_0100);
        drain();

        // full fence and store fence
        step(1, 1, 0, 0, 0);
        step(1, 4, 0, 0, 0);
        step(1, 3, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        idle(1);
        chk("R5 full fence blocks load despite no_alias", int'(may_exec), 8'b0000_0001);
        drain();

        // capacity: load queue 4, store queue whole table
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0);
        step(1, 2, 0, 0, 0);
        chk("R10 load fence refused when full", int'(alloc_ok), 0);
        chk("R10 lq_full flag", int'(lq_full), 1);
        step(1, 1, 0, 0, 0);
        chk("R9 store accepted with load queue full", int'(alloc_ok), 1);
        step(1, 6, 0, 0, 0);
        chk("R8 illegal kind refused", int'(alloc_ok), 0);
        drain();

        // random traffic
        for (int n = 0; n < 5000; n++) begin
            int ak = $urandom % 6;
            int ds = $urandom % N;
            bit dv = ($urandom % 3) != 0;
            if (ak == 5) ak = ($urandom % 2) ? 0 : 7;
            if (($urandom % 4) != 0)
                for (int i = N - 1; i >= 0; i--) if (exp_may(i)) ds = i;
            step(($urandom % 2) == 1, ak, dv, ds, ($urandom % 5) == 0);
        end
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule